// File: doc/BRIEF.md
# Sum-Check Framed Link with Stop-and-Wait Acknowledge

This block closes each outgoing byte frame with an 8-bit longitudinal check byte and checks that byte on the receiving side. The check byte is the two's complement of the modulo-256 sum of the frame's data bytes, so the data bytes and the check byte of an intact frame sum to zero. On the sending side, bytes enter over a valid/ready stream that carries a last-byte marker. The whole frame is held in a small store, and the frame is then sent on a byte link followed by its check byte.

The sending side is stop-and-wait. Once a frame is closed it takes no new input until an acknowledge returns carrying the frame's 1-bit sequence number. If no such acknowledge arrives within a programmable number of cycles, it sends the same frame again.

The receiving side sums every byte of a frame, check byte included. A frame whose total is not zero raises a one-cycle error pulse and gets no acknowledge. A good frame that carries the expected sequence number is reported as new and acknowledged. A good frame that repeats the previous number is flagged as out of sequence and acknowledged again, but it is not reported as new.

Top module: `lrcsum_link`

## Requirements
- R1: After a synchronous active-high reset, `in_ready` is 1, `tx_valid` is 0, `tx_seq` is 0 and every receive pulse output is 0. Both sides are idle, with their sums and sequence state cleared, even if reset hits in the middle of a frame.
- R2: The byte sent after the last data byte equals (0xFF - S) + 1 modulo 256, where S is the modulo-256 sum of the frame's data bytes. That byte is marked with `tx_end` = 1 and is followed by a cycle with `tx_valid` = 0.
- R3: A closing beat with `in_last` = 1 and `in_void` = 1 adds no data byte. A frame made of that beat alone is sent as the single check byte 0x00.
- R4: The data bytes are sent in input order, one per cycle on consecutive cycles, starting the cycle after the closing beat is accepted. A frame holds at most DEPTH data bytes.
- R5: `in_ready` is 0 from the acceptance of the closing beat until an acknowledge whose sequence number matches the current frame is taken. This holds while the frame is in flight and after a receive error.
- R6: On the cycle after a good end byte that carries the expected sequence number, `rx_new` and `rx_ack` pulse together, with `rx_ack_seq` equal to that frame's number. The expected number then toggles.
- R7: A frame whose byte total (check byte included) is not 0x00 pulses `rx_sum_err` for one cycle. It gives no `rx_ack` and no `rx_new`, and it leaves the expected sequence number unchanged.
- R8: A good frame whose sequence number differs from the expected one pulses `rx_seq_err` and `rx_ack` with that frame's number, and gives no `rx_new`.
- R9: While waiting, an acknowledge whose number differs from `tx_seq` is ignored. If no matching acknowledge arrives, the same frame bytes and check byte are sent again after `retry_limit`+1 waiting cycles.
- R10: `tx_seq` toggles only when a matching acknowledge is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retry_limit | input | TW | Waiting cycles before a frame is sent again |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 8 | Input data byte |
| in_last | input | 1 | Beat closes the frame |
| in_void | input | 1 | Beat carries no data byte (closing beat of an empty frame) |
| tx_valid | output | 1 | Link byte valid |
| tx_byte | output | 8 | Link byte |
| tx_end | output | 1 | Link byte is the check byte |
| tx_seq | output | 1 | Sequence number of the frame being sent |
| ack_in | input | 1 | Acknowledge pulse from the far end |
| ack_seq_in | input | 1 | Sequence number carried by the acknowledge |
| rx_valid | input | 1 | Received byte valid |
| rx_byte | input | 8 | Received byte |
| rx_end | input | 1 | Received byte is the check byte |
| rx_seq | input | 1 | Sequence number of the received frame |
| rx_ack | output | 1 | Acknowledge pulse |
| rx_ack_seq | output | 1 | Sequence number being acknowledged |
| rx_new | output | 1 | Good frame with a new sequence number |
| rx_sum_err | output | 1 | Byte total of the frame was not zero |
| rx_seq_err | output | 1 | Good frame repeating the previous sequence number |

## Verification
The duplicate-frame path is the hardest to reach from the ports, because it needs an acknowledge that is lost after the receiver has already accepted the frame. The bench loops the link back and suppresses the acknowledge until the first sequence-error pulse appears. This forces a timeout and a resend of an already-accepted frame, and it checks that the resend is flagged rather than counted as new. In the same way, a corruption mask on the looped link stays applied only until the first sum-error pulse, which exercises the error-then-resend path.

// File: rtl/lrcsum_pkg.sv
package lrcsum_pkg;

   typedef enum logic [1:0] {
      TX_IDLE,
      TX_SEND,
      TX_WAIT
   } tx_state_t;

   // Two's complement of an 8-bit running sum.
   function automatic logic [7:0] lrc_close(input logic [7:0] s);
      return (8'hFF - s) + 8'd1;
   endfunction

endpackage

// File: rtl/lrc_frame_store.sv
module lrc_frame_store #(
   parameter int DEPTH = 16,
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [IW-1:0] rd_addr,
   output logic [7:0]    rd_data
);

   logic [7:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_addr] <= wr_data;
   end

   assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/lrc_tx.sv
module lrc_tx
   import lrcsum_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int TW    = 8,
   localparam int AW = $clog2(DEPTH + 1),
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [TW-1:0] retry_limit,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [7:0]    in_data,
   input  logic          in_last,
   input  logic          in_void,
   output logic          tx_valid,
   output logic [7:0]    tx_byte,
   output logic          tx_end,
   output logic          tx_seq,
   input  logic          ack_in,
   input  logic          ack_seq_in
);

   generate
      if (DEPTH < 1 || DEPTH > 255) begin : g_bad_depth
         $error("lrc_tx: DEPTH must lie in 1..255");
      end
      if (TW < 2) begin : g_bad_tw
         $error("lrc_tx: TW must be at least 2");
      end
   endgenerate

   tx_state_t     state;
   logic [AW-1:0] cnt;
   logic [AW-1:0] idx;
   logic [7:0]    sum;
   logic [7:0]    chk;
   logic          seq;
   logic [TW-1:0] timer;
   logic [7:0]    nsum;
   logic [7:0]    rd_data;
   logic          wr_en;

   assign in_ready = (state == TX_IDLE);
   assign tx_seq   = seq;
   assign nsum     = sum + in_data;
   assign wr_en    = in_valid && in_ready && !in_void;

   lrc_frame_store #(.DEPTH(DEPTH)) i_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (cnt[IW-1:0]),
      .wr_data (in_data),
      .rd_addr (idx[IW-1:0]),
      .rd_data (rd_data)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= TX_IDLE;
         cnt      <= '0;
         idx      <= '0;
         sum      <= '0;
         chk      <= '0;
         seq      <= 1'b0;
         timer    <= '0;
         tx_valid <= 1'b0;
         tx_byte  <= '0;
         tx_end   <= 1'b0;
      end else begin
         tx_valid <= 1'b0;
         tx_end   <= 1'b0;
         case (state)
            TX_IDLE: begin
               if (in_valid) begin
                  if (!in_void) begin
                     cnt <= cnt + AW'(1);
                     sum <= nsum;
                  end
                  if (in_last) begin
                     chk   <= lrc_close(in_void ? sum : nsum);
                     idx   <= '0;
                     state <= TX_SEND;
                  end
               end
            end
            TX_SEND: begin
               tx_valid <= 1'b1;
               if (idx < cnt) begin
                  tx_byte <= rd_data;
                  idx     <= idx + AW'(1);
               end else begin
                  tx_byte <= chk;
                  tx_end  <= 1'b1;
                  timer   <= '0;
                  state   <= TX_WAIT;
               end
            end
            TX_WAIT: begin
               if (ack_in && (ack_seq_in == seq)) begin
                  seq   <= ~seq;
                  cnt   <= '0;
                  sum   <= '0;
                  state <= TX_IDLE;
               end else if (timer == retry_limit) begin
                  idx   <= '0;
                  state <= TX_SEND;
               end else begin
                  timer <= timer + TW'(1);
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end

   // R5
   busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
      tx_valid |-> !in_ready);

   // R2
   end_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (tx_valid && tx_end) |=> !tx_valid);

   // R10
   seq_flip_chk: assert property (@(posedge clk) disable iff (rst)
      (tx_seq != $past(tx_seq)) |-> $past(ack_in));

   // R4
   frame_fit_chk: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> (cnt < AW'(DEPTH)));

endmodule

// File: rtl/lrc_rx.sv
module lrc_rx
   import lrcsum_pkg::*;
#(
   parameter bit ZERO_SUM = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       rx_valid,
   input  logic [7:0] rx_byte,
   input  logic       rx_end,
   input  logic       rx_seq,
   output logic       rx_ack,
   output logic       rx_ack_seq,
   output logic       rx_new,
   output logic       rx_sum_err,
   output logic       rx_seq_err
);

   logic [7:0] acc;
   logic       exp_seq;
   logic [7:0] total;
   logic       good;

   assign total = acc + rx_byte;

   generate
      if (ZERO_SUM) begin : g_zero_total
         assign good = (total == 8'h00);
      end else begin : g_recompute
         assign good = (lrc_close(acc) == rx_byte);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         acc        <= '0;
         exp_seq    <= 1'b0;
         rx_ack     <= 1'b0;
         rx_ack_seq <= 1'b0;
         rx_new     <= 1'b0;
         rx_sum_err <= 1'b0;
         rx_seq_err <= 1'b0;
      end else begin
         rx_ack     <= 1'b0;
         rx_new     <= 1'b0;
         rx_sum_err <= 1'b0;
         rx_seq_err <= 1'b0;
         if (rx_valid) begin
            if (!rx_end) begin
               acc <= total;
            end else begin
               acc <= '0;
               if (!good) begin
                  rx_sum_err <= 1'b1;
               end else begin
                  rx_ack     <= 1'b1;
                  rx_ack_seq <= rx_seq;
                  if (rx_seq == exp_seq) begin
                     rx_new  <= 1'b1;
                     exp_seq <= ~exp_seq;
                  end else begin
                     rx_seq_err <= 1'b1;
                  end
               end
            end
         end
      end
   end

   // R7
   err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      rx_sum_err |-> (!rx_ack && !rx_new));

   // R7
   err_keep_seq_chk: assert property (@(posedge clk) disable iff (rst)
      rx_sum_err |-> (exp_seq == $past(exp_seq)));

   // R6
   new_acked_chk: assert property (@(posedge clk) disable iff (rst)
      rx_new |-> (rx_ack && (rx_ack_seq != exp_seq)));

   // R8
   one_verdict_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({rx_new, rx_sum_err, rx_seq_err}));

endmodule

// File: rtl/lrcsum_link.sv
module lrcsum_link #(
   parameter int DEPTH    = 16,
   parameter int TW       = 8,
   parameter bit ZERO_SUM = 1'b1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [TW-1:0] retry_limit,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [7:0]    in_data,
   input  logic          in_last,
   input  logic          in_void,
   output logic          tx_valid,
   output logic [7:0]    tx_byte,
   output logic          tx_end,
   output logic          tx_seq,
   input  logic          ack_in,
   input  logic          ack_seq_in,
   input  logic          rx_valid,
   input  logic [7:0]    rx_byte,
   input  logic          rx_end,
   input  logic          rx_seq,
   output logic          rx_ack,
   output logic          rx_ack_seq,
   output logic          rx_new,
   output logic          rx_sum_err,
   output logic          rx_seq_err
);

   lrc_tx #(.DEPTH(DEPTH), .TW(TW)) i_tx (
      .clk         (clk),
      .rst         (rst),
      .retry_limit (retry_limit),
      .in_valid    (in_valid),
      .in_ready    (in_ready),
      .in_data     (in_data),
      .in_last     (in_last),
      .in_void     (in_void),
      .tx_valid    (tx_valid),
      .tx_byte     (tx_byte),
      .tx_end      (tx_end),
      .tx_seq      (tx_seq),
      .ack_in      (ack_in),
      .ack_seq_in  (ack_seq_in)
   );

   lrc_rx #(.ZERO_SUM(ZERO_SUM)) i_rx (
      .clk        (clk),
      .rst        (rst),
      .rx_valid   (rx_valid),
      .rx_byte    (rx_byte),
      .rx_end     (rx_end),
      .rx_seq     (rx_seq),
      .rx_ack     (rx_ack),
      .rx_ack_seq (rx_ack_seq),
      .rx_new     (rx_new),
      .rx_sum_err (rx_sum_err),
      .rx_seq_err (rx_seq_err)
   );

endmodule

// File: tb/test_lrcsum_link.sv
`timescale 1ns/1ps
module test_lrcsum_link;

   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [TW-1:0] retry_limit = TW'(20);
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [7:0]    in_data = 8'h00;
   logic          in_last = 1'b0;
   logic          in_void = 1'b0;
   logic          tx_valid, tx_end, tx_seq;
   logic [7:0]    tx_byte;
   logic          ack_in, ack_seq_in;
   logic          rx_valid, rx_end, rx_seq;
   logic [7:0]    rx_byte;
   logic          rx_ack, rx_ack_seq, rx_new, rx_sum_err, rx_seq_err;

   logic          loop_ack = 1'b1;
   logic          man_ack = 1'b0;
   logic          man_ack_seq = 1'b0;
   logic [7:0]    corrupt_req = 8'h00;
   logic          drop_req = 1'b0;

   int checks = 0;
   int fails = 0;

   // monitor state
   logic [7:0] cap [64];
   logic       cap_e [64];
   int cap_n = 0, end_n = 0, new_n = 0, serr_n = 0, qerr_n = 0;
   int cyc = 0, end_cyc = 0, new_cyc = 0;
   logic [7:0] clr_tok = 8'd0, seen_tok = 8'd0;

   always #5 clk = ~clk;

   // loop-back wiring with fault injection
   assign rx_valid   = tx_valid;
   assign rx_byte    = tx_byte ^ ((serr_n == 0) ? corrupt_req : 8'h00);
   assign rx_end     = tx_end;
   assign rx_seq     = tx_seq;
   assign ack_in     = loop_ack ? (rx_ack && !(drop_req && qerr_n == 0)) : man_ack;
   assign ack_seq_in = loop_ack ? rx_ack_seq : man_ack_seq;

   lrcsum_link #(.DEPTH(16), .TW(TW), .ZERO_SUM(1'b1)) i_lrcsum_link (
      .clk(clk), .rst(rst), .retry_limit(retry_limit),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .in_last(in_last), .in_void(in_void),
      .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_end(tx_end), .tx_seq(tx_seq),
      .ack_in(ack_in), .ack_seq_in(ack_seq_in),
      .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_end(rx_end), .rx_seq(rx_seq),
      .rx_ack(rx_ack), .rx_ack_seq(rx_ack_seq), .rx_new(rx_new),
      .rx_sum_err(rx_sum_err), .rx_seq_err(rx_seq_err)
   );

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (clr_tok != seen_tok) begin
         seen_tok = clr_tok;
         cap_n = 0; end_n = 0; new_n = 0; serr_n = 0; qerr_n = 0;
      end else if (!rst) begin
         if (tx_valid && cap_n < 64) begin
            cap[cap_n]   = tx_byte;
            cap_e[cap_n] = tx_end;
            cap_n = cap_n + 1;
         end
         if (tx_valid && tx_end) begin
            if (end_n == 0) end_cyc = cyc;
            end_n = end_n + 1;
         end
         if (rx_new) begin
            if (new_n == 0) new_cyc = cyc;
            new_n = new_n + 1;
         end
         if (rx_sum_err) serr_n = serr_n + 1;
         if (rx_seq_err) qerr_n = qerr_n + 1;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      clr_tok = clr_tok + 8'd1;
      @(negedge clk);
      #1;
   endtask

   task automatic push(input logic [7:0] d, input bit last, input bit vd);
      in_valid = 1'b1; in_data = d; in_last = last; in_void = vd;
      @(posedge clk);
      #1;
      in_valid = 1'b0; in_last = 1'b0; in_void = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 400; k++) begin
         @(negedge clk);
         if (in_ready) break;
      end
   endtask

   // {len, b0, b1, b2, b3, check}
   localparam logic [47:0] VEC [6] = '{
      {8'd1, 8'h05, 8'h00, 8'h00, 8'h00, 8'hFB},
      {8'd2, 8'h80, 8'h80, 8'h00, 8'h00, 8'h00},
      {8'd3, 8'hFF, 8'h01, 8'h10, 8'h00, 8'hF0},
      {8'd4, 8'h12, 8'h34, 8'h56, 8'h78, 8'hEC},
      {8'd4, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h04},
      {8'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : main
      logic exp_seq;
      exp_seq = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      check(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
      check(tx_valid == 1'b0 && tx_seq == 1'b0, "R1 tx idle", int'({tx_valid, tx_seq}), 0);
      check({rx_ack, rx_new, rx_sum_err, rx_seq_err} == 4'b0, "R1 rx pulses",
            int'({rx_ack, rx_new, rx_sum_err, rx_seq_err}), 0);
      #1;

      // vector table: R2, R4, R5, R6, R10
      foreach (VEC[v]) begin
         int len;
         len = int'(VEC[v][47:40]);
         clear_mon();
         for (int k = 0; k < len; k++)
            push(VEC[v][39-8*k -: 8], k == len - 1, 1'b0);
         check(in_ready == 1'b0, "R5 busy after last", int'(in_ready), 0);
         wait_idle();
         check(cap_n == len + 1, "R4 byte count", cap_n, len + 1);
         for (int k = 0; k < len; k++)
            check(cap[k] == VEC[v][39-8*k -: 8] && !cap_e[k], "R4 data order",
                  int'(cap[k]), int'(VEC[v][39-8*k -: 8]));
         check(cap[len] == VEC[v][7:0] && cap_e[len], "R2 check byte",
               int'(cap[len]), int'(VEC[v][7:0]));
         check(end_n == 1 && new_n == 1, "R6 one new frame", new_n, 1);
         check(new_cyc == end_cyc + 1, "R6 new timing", new_cyc - end_cyc, 1);
         exp_seq = ~exp_seq;
         check(tx_seq == exp_seq, "R10 seq toggle", int'(tx_seq), int'(exp_seq));
         #1;
      end

      // R3 empty frame
      clear_mon();
      push(8'hAB, 1'b1, 1'b1);
      wait_idle();
      check(cap_n == 1 && cap[0] == 8'h00 && cap_e[0], "R3 empty frame check",
            int'(cap[0]), 0);
      exp_seq = ~exp_seq;
      #1;

      // R7 corruption then R9 resend
      clear_mon();
      corrupt_req = 8'h01;
      push(8'h02, 1'b0, 1'b0);
      push(8'h03, 1'b1, 1'b0);
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         if (serr_n != 0) break;
      end
      check(serr_n == 1 && new_n == 0, "R7 sum error, no new", serr_n, 1);
      check(in_ready == 1'b0, "R5 still busy after error", int'(in_ready), 0);
      wait_idle();
      corrupt_req = 8'h00;
      check(end_n == 2 && new_n == 1, "R9 resend after error", end_n, 2);
      check(cap_n == 6 && cap[3] == 8'h02 && cap[4] == 8'h03 && cap[5] == 8'hFB,
            "R9 same frame resent", int'(cap[5]), 8'hFB);
      check(qerr_n == 0, "R7 expected seq kept", qerr_n, 0);
      exp_seq = ~exp_seq;
      #1;

      // R8 lost acknowledge -> duplicate
      clear_mon();
      drop_req = 1'b1;
      push(8'h11, 1'b1, 1'b0);
      wait_idle();
      drop_req = 1'b0;
      check(new_n == 1 && qerr_n == 1, "R8 duplicate flagged", qerr_n, 1);
      check(end_n == 2, "R8 frame sent twice", end_n, 2);
      exp_seq = ~exp_seq;
      check(tx_seq == exp_seq, "R10 seq after duplicate ack", int'(tx_seq), int'(exp_seq));
      #1;

      // R9 wrong-number acknowledge ignored
      clear_mon();
      loop_ack = 1'b0;
      retry_limit = TW'(200);
      push(8'h22, 1'b1, 1'b0);
      repeat (6) @(negedge clk);
      #1;
      man_ack = 1'b1; man_ack_seq = ~tx_seq;
      @(posedge clk);
      #1 man_ack = 1'b0;
      @(negedge clk);
      check(in_ready == 1'b0 && tx_seq == exp_seq, "R9 wrong ack ignored", int'(in_ready), 0);
      #1;
      man_ack = 1'b1; man_ack_seq = tx_seq;
      @(posedge clk);
      #1 man_ack = 1'b0;
      @(negedge clk);
      exp_seq = ~exp_seq;
      check(in_ready == 1'b1 && tx_seq == exp_seq, "R10 matching ack taken",
            int'({in_ready, tx_seq}), int'({1'b1, exp_seq}));
      loop_ack = 1'b1;
      retry_limit = TW'(20);
      #1;

      // R1 reset in mid-frame
      push(8'hAA, 1'b0, 1'b0);
      push(8'h55, 1'b0, 1'b0);
      rst = 1'b1;
      @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      check(in_ready == 1'b1 && tx_seq == 1'b0 && !tx_valid, "R1 mid-frame reset",
            int'({in_ready, tx_seq, tx_valid}), 3'b100);
      #1;
      clear_mon();
      push(8'h05, 1'b1, 1'b0);
      wait_idle();
      check(cap_n == 2 && cap[1] == 8'hFB, "R1 sum cleared by reset", int'(cap[1]), 8'hFB);
      check(new_n == 1, "R1 rx seq cleared by reset", new_n, 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule